// File: doc/BRIEF.md
# Remote Control Pulse Pattern Classifier

This block decodes an infrared-style remote control waveform. A 16-bit counter advances only on cycles where a count-source enable is high. It times the intervals of a serial input that is synchronised first. A mode field picks what one measurement covers: the full period between rising edges, the high level alone, or each level on its own. Each finished measurement is latched into a measurement register. It is then compared against four inclusive min/max windows: header, data-0, data-1, and a special pattern. The special pattern is a header-window interval that arrives after the frame's header.

A frame-activity flag goes high on the mode's start edge. It drops once the running count exceeds the header, data-0 and data-1 maxima, which is how the block notices that a frame has ended. Matches on data-0 and data-1 deposit bits into a 48-bit receive buffer, filled from bit 0 upward. A bit counter and a full flag go with the buffer. An optional header gate makes the block ignore data until a header has been seen in the frame. All windows and controls are plain input ports.

Top module: `ir_pulse_classifier`

## Requirements
- R1: In mode 0 (mode = 2'b00) a measurement is the number of counted cycles between two rising edges of the synchronised input. It is latched into meas_val at the second rising edge, and the counter restarts from 0 at every rising edge.
- R2: In mode 1 (mode = 2'b01) the counter restarts at a rising edge. The measurement is latched at the following falling edge, so meas_val equals the high-level width.
- R3: In mode 2 (mode = 2'b10) every edge, rising or falling, ends one measurement and restarts the counter. Mode 3 (2'b11) behaves exactly as mode 0.
- R4: rx_active sets on the mode's start edge (the rising edge in modes 0, 1 and 3; either edge in mode 2). It clears one clock after the running count exceeds all three of hd_max, d0_max and d1_max.
- R5: A measurement m with hd_min <= m <= hd_max, taken while no header has yet been seen in the frame, sets hdr_match and clears the other three flags. Both window bounds are inclusive.
- R6: A measurement that misses the header window and lies in the data-0 window sets only d0_match. One that misses both and lies in the data-1 window sets only d1_match. A header-window measurement after the frame's header sets only sp_match. A measurement outside every window clears all four flags.
- R7: With hdr_en = 1, data-window measurements taken before the frame's header leave every flag unchanged and push no bit.
- R8: All four match flags clear when en is low, and when rx_active rises at the start of a new frame. They keep their value in every cycle with no measurement.
- R9: Each accepted data-0 or data-1 match writes 0 or 1 at buffer position bit_cnt (position 0 when bit_cnt is 48), then advances bit_cnt. After 48 advances bit_cnt goes from 48 to 1. buf_full is 1 exactly while bit_cnt is 48.
- R10: The measurement counter advances only on cycles where cnt_tick is high. It saturates at 16'hFFFF instead of wrapping.
- R11: With en low, the counter, rx_active, bit_cnt, buf_full and rx_buf are held at zero.
- R12: The edge that starts a frame (rx_active low) is not a measurement: meas_val and the flags other than the frame-start clear are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low clears the receiver state |
| cnt_tick | input | 1 | Count-source enable, one per counted cycle |
| rx_in | input | 1 | Asynchronous remote control input |
| mode | input | 2 | Measurement mode (00 period, 01 high width, 10 each level, 11 as 00) |
| hdr_en | input | 1 | Hold data classification off until a header is seen |
| hd_min | input | 16 | Header window minimum |
| hd_max | input | 16 | Header window maximum |
| d0_min | input | 16 | Data-0 window minimum |
| d0_max | input | 16 | Data-0 window maximum |
| d1_min | input | 16 | Data-1 window minimum |
| d1_max | input | 16 | Data-1 window maximum |
| meas_val | output | 16 | Last latched measurement |
| rx_active | output | 1 | Frame reception in progress |
| hdr_match | output | 1 | Header pattern matched |
| d0_match | output | 1 | Data-0 pattern matched |
| d1_match | output | 1 | Data-1 pattern matched |
| sp_match | output | 1 | Special pattern matched |
| rx_buf | output | 48 | Receive buffer |
| bit_cnt | output | 6 | Number of bits in the buffer (0 to 48) |
| buf_full | output | 1 | Buffer holds 48 bits |

## Verification
The bench places measurements exactly on each window's minimum and maximum and one count outside. An exclusive comparison would then drop a boundary pulse, or a loose one would accept the neighbour. It sends a second header-window pulse in the same frame, which a design without header tracking would report as a header instead of special. It sends data before the header with the gate on, which an ungated design would shift into the buffer. A 49th bit must wrap the counter to 1 and drop the full flag, and a design that wraps to 0 or keeps the flag miscompares there. A 66,000-cycle interval checks that the counter saturates and does not wrap to a small value that would fall into a window.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;

  typedef enum logic [1:0] {
    MODE_PERIOD = 2'b00,
    MODE_HIGH   = 2'b01,
    MODE_LEVEL  = 2'b10,
    MODE_ALT    = 2'b11
  } meas_mode_e;

  typedef struct packed {
    logic hdr;
    logic d0;
    logic d1;
    logic sp;
  } pat_flags_t;

  localparam pat_flags_t FLAGS_NONE = '{hdr: 1'b0, d0: 1'b0, d1: 1'b0, sp: 1'b0};

endpackage

// File: rtl/ir_rx_sync.sv
module ir_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '0;
    else     pipe_q <= {pipe_q[DEPTH-2:0], din};
  end

  // newest synchronised sample vs. the one before it
  assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/ir_rx_timer.sv
module ir_rx_timer
  import ir_rx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [1:0]       mode,
  input  logic             rise,
  input  logic             fall,
  input  logic [CNT_W-1:0] hd_max,
  input  logic [CNT_W-1:0] d0_max,
  input  logic [CNT_W-1:0] d1_max,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] meas_q,
  output logic             active_q,
  output logic             meas_vld,
  output logic             frame_start
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  meas_mode_e mode_e;
  logic start_w, end_w, over_w;

  assign mode_e = meas_mode_e'(mode);

  always_comb begin
    unique case (mode_e)
      MODE_HIGH: begin
        start_w = rise;
        end_w   = fall;
      end
      MODE_LEVEL: begin
        start_w = rise | fall;
        end_w   = rise | fall;
      end
      default: begin
        start_w = rise;
        end_w   = rise;
      end
    endcase
  end

  assign over_w      = (cnt_q > hd_max) && (cnt_q > d0_max) && (cnt_q > d1_max);
  assign meas_vld    = en & end_w & active_q;
  assign frame_start = en & start_w & ~active_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else begin
      if (start_w)                      cnt_q <= '0;
      else if (tick && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;

      if (start_w)     active_q <= 1'b1;
      else if (over_w) active_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           meas_q <= '0;
    else if (meas_vld) meas_q <= cnt_q;
  end

  // R4
  act_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(active_q) |-> $past(frame_start));

  // R10
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !start_w && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  // R10
  cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !start_w && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/ir_rx_classify.sv
module ir_rx_classify
  import ir_rx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             hdr_en,
  input  logic             frame_start,
  input  logic             meas_vld,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] hd_min,
  input  logic [CNT_W-1:0] hd_max,
  input  logic [CNT_W-1:0] d0_min,
  input  logic [CNT_W-1:0] d0_max,
  input  logic [CNT_W-1:0] d1_min,
  input  logic [CNT_W-1:0] d1_max,
  output pat_flags_t       flags_q,
  output logic             push,
  output logic             push_bit
);
  logic in_hd, in_d0, in_d1, data_ok, hdr_seen_q;
  pat_flags_t flags_d;

  assign in_hd   = (cnt >= hd_min) && (cnt <= hd_max);
  assign in_d0   = (cnt >= d0_min) && (cnt <= d0_max);
  assign in_d1   = (cnt >= d1_min) && (cnt <= d1_max);
  assign data_ok = ~hdr_en | hdr_seen_q;

  assign push     = meas_vld & ~in_hd & (in_d0 | in_d1) & data_ok;
  assign push_bit = ~in_d0;

  always_comb begin
    flags_d = flags_q;
    if (in_hd) begin
      flags_d     = FLAGS_NONE;
      flags_d.hdr = ~hdr_seen_q;
      flags_d.sp  = hdr_seen_q;
    end else if (in_d0) begin
      if (data_ok) begin
        flags_d    = FLAGS_NONE;
        flags_d.d0 = 1'b1;
      end
    end else if (in_d1) begin
      if (data_ok) begin
        flags_d    = FLAGS_NONE;
        flags_d.d1 = 1'b1;
      end
    end else begin
      flags_d = FLAGS_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en || frame_start) begin
      flags_q    <= FLAGS_NONE;
      hdr_seen_q <= 1'b0;
    end else if (meas_vld) begin
      flags_q <= flags_d;
      if (in_hd) hdr_seen_q <= 1'b1;
    end
  end

  // R6
  flags_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flags_q));

  // R8
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !meas_vld && !frame_start) |=> $stable(flags_q));

  // R7
  gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && hdr_en && !hdr_seen_q && meas_vld && !in_hd && (in_d0 || in_d1))
      |=> $stable(flags_q));
endmodule

// File: rtl/ir_rx_buffer.sv
module ir_rx_buffer #(
  parameter int BITS = 48,
  parameter int CW   = $clog2(BITS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            push,
  input  logic            push_bit,
  output logic [BITS-1:0] buf_q,
  output logic [CW-1:0]   cnt_q,
  output logic            full_q
);
  localparam logic [CW-1:0] FULL_CNT = CW'(BITS);

  logic [CW-1:0] idx, cnt_nxt;

  assign idx     = (cnt_q == FULL_CNT) ? '0 : cnt_q;
  assign cnt_nxt = idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      buf_q  <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else if (push) begin
      buf_q[idx] <= push_bit;
      cnt_q      <= cnt_nxt;
      full_q     <= (cnt_nxt == FULL_CNT);
    end
  end

  // R9
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL_CNT);

  // R9
  full_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(full_q) |-> (cnt_q <= 1));
endmodule

// File: rtl/ir_pulse_classifier.sv
module ir_pulse_classifier
  import ir_rx_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int BUF_BITS = 48,
  parameter int SYNC_N   = 2,
  parameter int BCNT_W   = $clog2(BUF_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                cnt_tick,
  input  logic                rx_in,
  input  logic [1:0]          mode,
  input  logic                hdr_en,
  input  logic [CNT_W-1:0]    hd_min,
  input  logic [CNT_W-1:0]    hd_max,
  input  logic [CNT_W-1:0]    d0_min,
  input  logic [CNT_W-1:0]    d0_max,
  input  logic [CNT_W-1:0]    d1_min,
  input  logic [CNT_W-1:0]    d1_max,
  output logic [CNT_W-1:0]    meas_val,
  output logic                rx_active,
  output logic                hdr_match,
  output logic                d0_match,
  output logic                d1_match,
  output logic                sp_match,
  output logic [BUF_BITS-1:0] rx_buf,
  output logic [BCNT_W-1:0]   bit_cnt,
  output logic                buf_full
);
  logic rise, fall, meas_vld, frame_start, push, push_bit;
  logic [CNT_W-1:0] cnt;
  pat_flags_t flags;

  ir_rx_sync #(.STAGES(SYNC_N)) u_sync (
    .clk (clk), .rst (rst), .din (rx_in), .rise (rise), .fall (fall)
  );

  ir_rx_timer #(.CNT_W(CNT_W)) u_timer (
    .clk (clk), .rst (rst), .en (en), .tick (cnt_tick), .mode (mode),
    .rise (rise), .fall (fall),
    .hd_max (hd_max), .d0_max (d0_max), .d1_max (d1_max),
    .cnt_q (cnt), .meas_q (meas_val), .active_q (rx_active),
    .meas_vld (meas_vld), .frame_start (frame_start)
  );

  ir_rx_classify #(.CNT_W(CNT_W)) u_class (
    .clk (clk), .rst (rst), .en (en), .hdr_en (hdr_en),
    .frame_start (frame_start), .meas_vld (meas_vld), .cnt (cnt),
    .hd_min (hd_min), .hd_max (hd_max),
    .d0_min (d0_min), .d0_max (d0_max),
    .d1_min (d1_min), .d1_max (d1_max),
    .flags_q (flags), .push (push), .push_bit (push_bit)
  );

  ir_rx_buffer #(.BITS(BUF_BITS), .CW(BCNT_W)) u_buf (
    .clk (clk), .rst (rst), .en (en), .push (push), .push_bit (push_bit),
    .buf_q (rx_buf), .cnt_q (bit_cnt), .full_q (buf_full)
  );

  assign hdr_match = flags.hdr;
  assign d0_match  = flags.d0;
  assign d1_match  = flags.d1;
  assign sp_match  = flags.sp;
endmodule

// File: tb/ir_pulse_classifier_tb.sv
module ir_pulse_classifier_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic cnt_tick = 1'b1;
  logic rx_in = 1'b0;
  logic [1:0] mode = 2'b00;
  logic hdr_en = 1'b0;
  logic [15:0] hd_min = 16'd80, hd_max = 16'd100;
  logic [15:0] d0_min = 16'd10, d0_max = 16'd20;
  logic [15:0] d1_min = 16'd30, d1_max = 16'd40;
  logic [15:0] meas_val;
  logic rx_active, hdr_match, d0_match, d1_match, sp_match, buf_full;
  logic [47:0] rx_buf;
  logic [5:0] bit_cnt;
  logic half_rate = 1'b0;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ir_pulse_classifier u_dut (
    .clk (clk), .rst (rst), .en (en), .cnt_tick (cnt_tick), .rx_in (rx_in),
    .mode (mode), .hdr_en (hdr_en),
    .hd_min (hd_min), .hd_max (hd_max), .d0_min (d0_min), .d0_max (d0_max),
    .d1_min (d1_min), .d1_max (d1_max),
    .meas_val (meas_val), .rx_active (rx_active),
    .hdr_match (hdr_match), .d0_match (d0_match), .d1_match (d1_match),
    .sp_match (sp_match), .rx_buf (rx_buf), .bit_cnt (bit_cnt), .buf_full (buf_full)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_s1, m_s2, m_s3, m_cnt, m_meas, m_act, m_hs, m_bc, m_full;
  bit m_h, m_d0, m_d1, m_sp;
  logic [47:0] m_buf;

  always @(posedge clk) begin
    bit rs, fl, st, ed, vld, fs, ov, ih, i0, i1, ok;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_cnt = 0; m_meas = 0; m_act = 0;
      m_hs = 0; m_bc = 0; m_full = 0; m_buf = '0;
      m_h = 0; m_d0 = 0; m_d1 = 0; m_sp = 0;
    end else begin
      rs = (m_s2 == 1) && (m_s3 == 0);
      fl = (m_s2 == 0) && (m_s3 == 1);
      st = (mode == 2'b10) ? (rs || fl) : rs;
      ed = (mode == 2'b01) ? fl : ((mode == 2'b10) ? (rs || fl) : rs);
      ov = (m_cnt > int'(hd_max)) && (m_cnt > int'(d0_max)) && (m_cnt > int'(d1_max));
      if (!en) begin
        m_cnt = 0; m_act = 0; m_hs = 0; m_bc = 0; m_full = 0; m_buf = '0;
        m_h = 0; m_d0 = 0; m_d1 = 0; m_sp = 0;
      end else begin
        vld = ed && (m_act == 1);
        fs  = st && (m_act == 0);
        if (fs) begin
          m_h = 0; m_d0 = 0; m_d1 = 0; m_sp = 0; m_hs = 0;
        end else if (vld) begin
          m_meas = m_cnt;
          ih = (m_cnt >= int'(hd_min)) && (m_cnt <= int'(hd_max));
          i0 = (m_cnt >= int'(d0_min)) && (m_cnt <= int'(d0_max));
          i1 = (m_cnt >= int'(d1_min)) && (m_cnt <= int'(d1_max));
          ok = !hdr_en || (m_hs == 1);
          if (ih) begin
            m_h = (m_hs == 0); m_sp = (m_hs == 1); m_d0 = 0; m_d1 = 0; m_hs = 1;
          end else if ((i0 || i1) && ok) begin
            m_h = 0; m_sp = 0; m_d0 = i0; m_d1 = !i0;
            if (m_bc == 48) m_bc = 0;
            m_buf[m_bc] = !i0;
            m_bc = m_bc + 1;
            m_full = (m_bc == 48);
          end else if (!(i0 || i1)) begin
            m_h = 0; m_d0 = 0; m_d1 = 0; m_sp = 0;
          end
        end
        if (st) m_cnt = 0;
        else if (cnt_tick && m_cnt < 65535) m_cnt = m_cnt + 1;
        if (st) m_act = 1;
        else if (ov) m_act = 0;
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(rx_in);
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R1 meas_val", 64'(meas_val), 64'(m_meas));
      chk("R4 rx_active", 64'(rx_active), 64'(m_act));
      chk("R6 flags", 64'({hdr_match, d0_match, d1_match, sp_match}),
          64'({m_h, m_d0, m_d1, m_sp}));
      chk("R9 rx_buf", 64'(rx_buf), 64'(m_buf));
      chk("R9 bit_cnt", 64'(bit_cnt), 64'(m_bc));
      chk("R9 buf_full", 64'(buf_full), 64'(m_full));
    end
  end

  // count source: every cycle or every other cycle
  always @(negedge clk) cnt_tick <= half_rate ? ~cnt_tick : 1'b1;

  task automatic hold(input logic v, input int n);
    rx_in = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic edge_hi();
    hold(1'b1, 4);
  endtask

  task automatic restart(input logic [1:0] m, input logic he);
    en = 1'b0;
    rx_in = 1'b0;
    repeat (4) @(negedge clk);
    mode = m;
    hdr_en = he;
    en = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic flags_are(input string req, input logic [3:0] exp);
    chk(req, 64'({hdr_match, d0_match, d1_match, sp_match}), 64'(exp));
  endtask

  function automatic bit pat_bit(input int i);
    return (i % 3 == 0) || (i % 7 == 2);
  endfunction

  initial begin
    logic [47:0] exp_buf;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk("R11 reset bit_cnt", 64'(bit_cnt), 64'd0);
    chk("R11 reset rx_active", 64'(rx_active), 64'd0);
    flags_are("R8 reset flags", 4'b0000);

    // ---- mode 0 with header gate ----
    restart(2'b00, 1'b1);
    edge_hi();
    chk("R12 frame start leaves meas_val", 64'(meas_val), 64'd0);
    chk("R4 rx_active set on start edge", 64'(rx_active), 64'd1);
    hold(1'b0, 16 - 4); edge_hi();
    flags_are("R7 data before header ignored", 4'b0000);
    chk("R7 no bit pushed before header", 64'(bit_cnt), 64'd0);
    hold(1'b0, 91 - 4); edge_hi();
    flags_are("R5 header match", 4'b1000);
    chk("R1 period measurement", 64'(meas_val), 64'd90);
    hold(1'b0, 11 - 4); edge_hi();
    flags_are("R6 d0 at inclusive min", 4'b0100);
    hold(1'b0, 41 - 4); edge_hi();
    flags_are("R6 d1 at inclusive max", 4'b0010);
    hold(1'b0, 101 - 4); edge_hi();
    flags_are("R6 second header is special", 4'b0001);
    hold(1'b0, 22 - 4); edge_hi();
    flags_are("R6 outside all windows clears", 4'b0000);
    hold(1'b0, 21 - 4); edge_hi();
    flags_are("R6 d0 at inclusive max", 4'b0100);
    hold(1'b0, 300);
    chk("R4 timeout clears rx_active", 64'(rx_active), 64'd0);
    held = meas_val;
    edge_hi();
    chk("R12 new frame edge not measured", 64'(meas_val), 64'(held));
    flags_are("R8 new frame clears flags", 4'b0000);
    hold(1'b0, 300);

    // ---- fill the buffer ----
    restart(2'b00, 1'b1);
    edge_hi();
    hold(1'b0, 81 - 4); edge_hi();
    flags_are("R5 header at inclusive min", 4'b1000);
    exp_buf = '0;
    for (int i = 0; i < 48; i++) begin
      exp_buf[i] = pat_bit(i);
      hold(1'b0, (pat_bit(i) ? 36 : 16) - 4);
      edge_hi();
    end
    chk("R9 full bit count", 64'(bit_cnt), 64'd48);
    chk("R9 full flag set", 64'(buf_full), 64'd1);
    chk("R9 buffer LSB first", 64'(rx_buf), 64'(exp_buf));
    hold(1'b0, 36 - 4); edge_hi();
    exp_buf[0] = 1'b1;
    chk("R9 wrap to one", 64'(bit_cnt), 64'd1);
    chk("R9 full flag clears on wrap", 64'(buf_full), 64'd0);
    chk("R9 wrap writes position 0", 64'(rx_buf), 64'(exp_buf));
    en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 disable clears bit_cnt", 64'(bit_cnt), 64'd0);
    flags_are("R8 disable clears flags", 4'b0000);

    // ---- mode 1: high width ----
    restart(2'b01, 1'b0);
    hold(1'b1, 15);
    hold(1'b0, 50);
    chk("R2 high width measured", 64'(meas_val), 64'd14);
    flags_are("R2 high width classed d0", 4'b0100);
    hold(1'b1, 35);
    hold(1'b0, 300);
    chk("R2 second high width", 64'(meas_val), 64'd34);
    chk("R4 timeout after low tail", 64'(rx_active), 64'd0);

    // ---- mode 2: each level ----
    restart(2'b10, 1'b0);
    hold(1'b1, 36);
    hold(1'b0, 16);
    chk("R3 high level measured", 64'(meas_val), 64'd35);
    flags_are("R3 high level d1", 4'b0010);
    hold(1'b1, 300);
    chk("R3 low level measured", 64'(meas_val), 64'd15);
    flags_are("R3 low level d0", 4'b0100);
    chk("R4 timeout in high level", 64'(rx_active), 64'd0);

    // ---- mode 3 acts as mode 0 ----
    restart(2'b11, 1'b0);
    edge_hi();
    hold(1'b0, 16 - 4); edge_hi();
    chk("R3 mode 3 period", 64'(meas_val), 64'd15);
    flags_are("R3 mode 3 d0", 4'b0100);
    hold(1'b0, 300);

    // ---- half-rate count source ----
    restart(2'b00, 1'b0);
    half_rate = 1'b1;
    edge_hi();
    hold(1'b0, 40 - 4); edge_hi();
    chk("R10 half-rate count low", 64'(meas_val >= 16'd18), 64'd1);
    chk("R10 half-rate count high", 64'(meas_val <= 16'd20), 64'd1);
    hold(1'b0, 400);
    half_rate = 1'b0;

    // ---- saturation ----
    hd_max = 16'hFFFF;
    restart(2'b00, 1'b0);
    edge_hi();
    hold(1'b0, 66000);
    chk("R10 still active at saturation", 64'(rx_active), 64'd1);
    edge_hi();
    chk("R10 counter saturates", 64'(meas_val), 64'hFFFF);
    flags_are("R10 saturated value in header window", 4'b1000);
    en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 disable clears rx_active", 64'(rx_active), 64'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule